// File: doc/BRIEF.md
# Non-Restoring Divide Step Unit

This block carries out one iteration of one-bit-per-step non-restoring division. A processor pipeline uses it as the datapath of its divide-step instruction. A 32-bit partial remainder, a 32-bit divisor and three status flags go in: a quotient-sign flag Q, a divisor-sign flag M and a carry-in flag T. Out come the next partial remainder, the new Q and the new T. M passes through unchanged. Whether the step adds or subtracts is decided only by the flags, so a caller gets a full division by setting the flags beforehand and feeding the flags from each step back into the next. The step logic is combinational. A parameter can place a register stage behind it, and that stage only loads when a request is valid.

The same step logic also sits inside a small sequencer for unsigned 64-by-32 division. A start pulse loads the high dividend word as the partial remainder and the low dividend word as a shift register, with Q, M and T all clear. The sequencer then runs one step per clock for 32 clocks. On each clock the top bit of the low word becomes the incoming T, and the T the step produces is shifted into the bottom of the low word. When the run ends, the low word holds the quotient. That quotient is put on the output and kept there, and a done pulse is raised.

Top module: `nrdiv_step_unit`

## Requirements
- R1: A step first shifts the partial remainder left by one bit, with T entering at bit 0 and the top bit dropped. It then subtracts the divisor if the incoming Q equals M, and adds it otherwise. All arithmetic is 32-bit and wraps modulo 2^32.
- R2: The new Q is the XOR of three bits: the partial remainder's bit 31 taken before the shift, M, and the carry out of the add or the borrow out of the subtract. Any overflow past bit 31 reaches the result only through this bit.
- R3: After a step, T is 1 exactly when the new Q equals M.
- R4: The M output equals the M input of the same step.
- R5: With the register stage enabled (the default), the step results and the valid flag appear one clock after the request. While the request valid is low, the step outputs keep their last values.
- R6: After synchronous active-low reset, every step output, the step valid flag, busy, done and the quotient are all 0.
- R7: A start seen while idle loads a run and raises busy on the next clock. Done is high for exactly one clock: the clock after the 32nd step edge, that is, 32 edges after the start edge. Busy is low in that clock.
- R8: When the high dividend word is below the divisor, the quotient of a run equals the unsigned integer quotient of the 64-bit dividend {high, low} by the divisor. The run starts with Q, M and T all zero.
- R9: A start that arrives while busy is ignored. The run in progress finishes at its original time with its original quotient.
- R10: Between runs, the quotient output holds the result of the last completed run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| stp_valid | input | 1 | Single-step request valid |
| stp_rem | input | 32 | Incoming partial remainder |
| stp_dvs | input | 32 | Divisor |
| stp_q | input | 1 | Incoming Q flag |
| stp_m | input | 1 | M flag (divisor sign) |
| stp_t | input | 1 | Incoming T flag |
| stp_valid_o | output | 1 | Step result valid |
| stp_rem_o | output | 32 | Next partial remainder |
| stp_q_o | output | 1 | New Q flag |
| stp_m_o | output | 1 | M flag passed through |
| stp_t_o | output | 1 | New T flag |
| run_start | input | 1 | Start a 32-step unsigned division |
| run_hi | input | 32 | High dividend word (must be below the divisor) |
| run_lo | input | 32 | Low dividend word |
| run_dvs | input | 32 | Divisor for the run |
| run_busy | output | 1 | Run in progress |
| run_done | output | 1 | One-clock pulse when the quotient is ready |
| run_quot | output | 32 | Quotient of the last completed run |

## Verification
A wrong add/subtract choice or a wrong carry/borrow shows at the single-step outputs one clock after the request: the remainder, the new Q and the new T all differ from the values the bench computes separately. Inside a run, one wrong step drives the Q flag fed back to the next step off course. From then on the later quotient bits are wrong, so a single bad step becomes visible in the quotient when done rises 32 clocks after the start. A step counter that is off shows as done arriving at the wrong clock, and a start that is not ignored while busy shows as a changed quotient or a moved done pulse.

// File: rtl/nrdiv_pkg.sv
// Shared definitions for the non-restoring divide step unit.
// Assumes: one data width for remainder and divisor throughout.
package nrdiv_pkg;

    // Default operand width
    localparam int DATA_W = 32;

    // Status flags carried from one step to the next
    typedef struct packed {
        logic q;   // quotient sign / provisional quotient bit
        logic m;   // divisor sign, never modified by a step
        logic t;   // bit shifted in, then quotient bit out
    } flags_t;

endpackage

// File: rtl/nrdiv_step_core.sv
// One combinational non-restoring division step.
// Shifts the remainder left with T entering at bit 0, then subtracts the
// divisor when Q equals M and adds it otherwise. The carry or borrow out of
// bit W-1 combines with the old top bit and M to form the new Q.
// Assumes: unsigned modular W-bit arithmetic; no state.
module nrdiv_step_core
    import nrdiv_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  logic [W-1:0] rem_i,
    input  logic [W-1:0] dvs_i,
    input  flags_t       flg_i,
    output logic [W-1:0] rem_o,
    output flags_t       flg_o
);

    logic         top_bit;
    logic [W-1:0] shifted;
    logic         do_sub;
    logic [W:0]   wide_res;
    logic         carry_bit;
    logic         new_q;

    // Capture the top bit before the shift, then form the shifted remainder
    always_comb begin
        top_bit = rem_i[W-1];
        shifted = {rem_i[W-2:0], flg_i.t};
    end

    // Add or subtract in W+1 bits; bit W is carry (add) or borrow (sub)
    always_comb begin
        do_sub = (flg_i.q == flg_i.m);
        if (do_sub) begin
            wide_res = {1'b0, shifted} - {1'b0, dvs_i};
        end else begin
            wide_res = {1'b0, shifted} + {1'b0, dvs_i};
        end
        carry_bit = wide_res[W];
    end

    // New flags: Q from the XOR rule, T from Q against M, M passes through
    always_comb begin
        new_q   = top_bit ^ flg_i.m ^ carry_bit;
        rem_o   = wide_res[W-1:0];
        flg_o.q = new_q;
        flg_o.m = flg_i.m;
        flg_o.t = (new_q == flg_i.m);
    end

endmodule

// File: rtl/nrdiv_out_stage.sv
// Optional output stage behind the single-step path.
// With OUT_REG set, results load on a valid request and hold otherwise;
// with OUT_REG clear, the stage is a wire.
// Assumes: synchronous active-low reset.
module nrdiv_out_stage
    import nrdiv_pkg::*;
#(
    parameter int W       = DATA_W,
    parameter bit OUT_REG = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         vld_i,
    input  logic [W-1:0] rem_i,
    input  flags_t       flg_i,
    output logic         vld_o,
    output logic [W-1:0] rem_o,
    output flags_t       flg_o
);

    generate
        if (OUT_REG) begin : g_reg
            logic         vld_r;
            logic [W-1:0] rem_r;
            flags_t       flg_r;

            // Valid follows the request with one clock of delay
            always_ff @(posedge clk) begin
                if (!rst_n) vld_r <= 1'b0;
                else        vld_r <= vld_i;
            end

            // Results load only on a valid request
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    rem_r <= '0;
                    flg_r <= '0;
                end else if (vld_i) begin
                    rem_r <= rem_i;
                    flg_r <= flg_i;
                end
            end

            assign vld_o = vld_r;
            assign rem_o = rem_r;
            assign flg_o = flg_r;
        end else begin : g_wire
            assign vld_o = vld_i;
            assign rem_o = rem_i;
            assign flg_o = flg_i;
        end
    endgenerate

endmodule

// File: rtl/nrdiv_seq.sv
// Sequencer for unsigned 2W-by-W division by repeated steps.
// Loads the high word as the remainder and the low word as a shift register;
// each clock the low word's top bit feeds T and the step's T is shifted in.
// After W steps the low word is the quotient.
// Assumes: high word below divisor; Q, M and T start at zero; start is
// ignored while a run is in progress.
module nrdiv_seq
    import nrdiv_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start_i,
    input  logic [W-1:0] hi_i,
    input  logic [W-1:0] lo_i,
    input  logic [W-1:0] dvs_i,
    output logic         busy_o,
    output logic         done_o,
    output logic [W-1:0] quot_o
);

    localparam int CW = (W > 1) ? $clog2(W) : 1;
    localparam logic [CW-1:0] LAST = CW'(W - 1);

    logic [W-1:0]  rem_r;
    logic [W-1:0]  lo_r;
    logic [W-1:0]  dvs_r;
    logic          q_r;
    logic [CW-1:0] cnt_r;
    logic          busy_r;
    logic          done_r;
    logic [W-1:0]  quot_r;

    flags_t        flg_in;
    flags_t        flg_out;
    logic [W-1:0]  rem_nxt;
    logic          accept;
    logic          last_step;

    // Flags presented to the step: M fixed at zero for unsigned division
    always_comb begin
        flg_in.q  = q_r;
        flg_in.m  = 1'b0;
        flg_in.t  = lo_r[W-1];
        accept    = start_i && !busy_r;
        last_step = busy_r && (cnt_r == LAST);
    end

    nrdiv_step_core #(.W(W)) u_core (
        .rem_i (rem_r),
        .dvs_i (dvs_r),
        .flg_i (flg_in),
        .rem_o (rem_nxt),
        .flg_o (flg_out)
    );

    // Datapath: load on accepted start, step while busy
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem_r <= '0;
            lo_r  <= '0;
            dvs_r <= '0;
            q_r   <= 1'b0;
        end else if (accept) begin
            rem_r <= hi_i;
            lo_r  <= lo_i;
            dvs_r <= dvs_i;
            q_r   <= 1'b0;
        end else if (busy_r) begin
            rem_r <= rem_nxt;
            lo_r  <= {lo_r[W-2:0], flg_out.t};
            q_r   <= flg_out.q;
        end
    end

    // Control: step counter, busy and the done pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_r  <= '0;
            busy_r <= 1'b0;
            done_r <= 1'b0;
        end else begin
            done_r <= last_step;
            if (accept) begin
                cnt_r  <= '0;
                busy_r <= 1'b1;
            end else if (last_step) begin
                busy_r <= 1'b0;
            end else if (busy_r) begin
                cnt_r  <= cnt_r + 1'b1;
            end
        end
    end

    // Quotient capture on the final step; held until the next run ends
    always_ff @(posedge clk) begin
        if (!rst_n)         quot_r <= '0;
        else if (last_step) quot_r <= {lo_r[W-2:0], flg_out.t};
    end

    assign busy_o = busy_r;
    assign done_o = done_r;
    assign quot_o = quot_r;

endmodule

// File: rtl/nrdiv_step_unit.sv
// Top: single-step non-restoring division path plus a W-step unsigned
// division sequencer built from the same step logic.
// Assumes: synchronous active-low reset; flags are preset by the caller.
module nrdiv_step_unit
    import nrdiv_pkg::*;
#(
    parameter int W       = DATA_W,
    parameter bit OUT_REG = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         stp_valid,
    input  logic [W-1:0] stp_rem,
    input  logic [W-1:0] stp_dvs,
    input  logic         stp_q,
    input  logic         stp_m,
    input  logic         stp_t,
    output logic         stp_valid_o,
    output logic [W-1:0] stp_rem_o,
    output logic         stp_q_o,
    output logic         stp_m_o,
    output logic         stp_t_o,
    input  logic         run_start,
    input  logic [W-1:0] run_hi,
    input  logic [W-1:0] run_lo,
    input  logic [W-1:0] run_dvs,
    output logic         run_busy,
    output logic         run_done,
    output logic [W-1:0] run_quot
);

    flags_t       s_flg_in;
    flags_t       s_flg_cmb;
    flags_t       s_flg_out;
    logic [W-1:0] s_rem_cmb;

    // Pack the step flags
    always_comb begin
        s_flg_in.q = stp_q;
        s_flg_in.m = stp_m;
        s_flg_in.t = stp_t;
    end

    nrdiv_step_core #(.W(W)) u_step (
        .rem_i (stp_rem),
        .dvs_i (stp_dvs),
        .flg_i (s_flg_in),
        .rem_o (s_rem_cmb),
        .flg_o (s_flg_cmb)
    );

    nrdiv_out_stage #(.W(W), .OUT_REG(OUT_REG)) u_out (
        .clk   (clk),
        .rst_n (rst_n),
        .vld_i (stp_valid),
        .rem_i (s_rem_cmb),
        .flg_i (s_flg_cmb),
        .vld_o (stp_valid_o),
        .rem_o (stp_rem_o),
        .flg_o (s_flg_out)
    );

    // Unpack the step flags
    always_comb begin
        stp_q_o = s_flg_out.q;
        stp_m_o = s_flg_out.m;
        stp_t_o = s_flg_out.t;
    end

    nrdiv_seq #(.W(W)) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (run_start),
        .hi_i    (run_hi),
        .lo_i    (run_lo),
        .dvs_i   (run_dvs),
        .busy_o  (run_busy),
        .done_o  (run_done),
        .quot_o  (run_quot)
    );

endmodule

// File: rtl/nrdiv_step_chk.sv
// Assertion checker for nrdiv_step_unit, attached with bind.
// Assumes: synchronous active-low reset; observes ports only.
module nrdiv_step_chk #(
    parameter int W       = 32,
    parameter bit OUT_REG = 1'b1
) (
    input logic         clk,
    input logic         rst_n,
    input logic         stp_valid,
    input logic [W-1:0] stp_rem,
    input logic         stp_m,
    input logic         stp_valid_o,
    input logic [W-1:0] stp_rem_o,
    input logic         stp_q_o,
    input logic         stp_m_o,
    input logic         stp_t_o,
    input logic         run_start,
    input logic         run_busy,
    input logic         run_done,
    input logic [W-1:0] run_quot
);

    logic [15:0] lat_cnt;

    // Edges counted since the last accepted start
    always_ff @(posedge clk) begin
        if (!rst_n)                      lat_cnt <= '0;
        else if (run_start && !run_busy) lat_cnt <= '0;
        else if (run_busy)               lat_cnt <= lat_cnt + 16'd1;
    end

    p_t_follows_q_r3: assert property (@(posedge clk) disable iff (!rst_n)
        stp_valid_o |-> (stp_t_o == (stp_q_o == stp_m_o)));

    generate
        if (OUT_REG) begin : g_reg_chk
            p_m_passes_r4: assert property (@(posedge clk) disable iff (!rst_n)
                stp_valid |=> (stp_m_o == $past(stp_m)));
            p_valid_delay_r5: assert property (@(posedge clk) disable iff (!rst_n)
                stp_valid |=> stp_valid_o);
            p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
                !stp_valid |=> $stable(stp_rem_o));
        end
    endgenerate

    p_start_loads_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (run_start && !run_busy) |=> run_busy);
    p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        run_done |=> !run_done);
    p_done_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({run_busy, run_done}));
    p_latency_r7: assert property (@(posedge clk) disable iff (!rst_n)
        run_done |-> (lat_cnt == 16'(W)));
    p_busy_quot_r9: assert property (@(posedge clk) disable iff (!rst_n)
        run_busy |=> $stable(run_quot) || run_done);
    p_quot_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_busy && !run_start) |=> $stable(run_quot));

endmodule

bind nrdiv_step_unit nrdiv_step_chk #(.W(W), .OUT_REG(OUT_REG)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .stp_valid   (stp_valid),
    .stp_rem     (stp_rem),
    .stp_m       (stp_m),
    .stp_valid_o (stp_valid_o),
    .stp_rem_o   (stp_rem_o),
    .stp_q_o     (stp_q_o),
    .stp_m_o     (stp_m_o),
    .stp_t_o     (stp_t_o),
    .run_start   (run_start),
    .run_busy    (run_busy),
    .run_done    (run_done),
    .run_quot    (run_quot)
);

// File: tb/tb_nrdiv_step_unit.sv
// Self-checking bench: directed and seeded random steps and divisions.
module tb_nrdiv_step_unit;

    localparam int W = 32;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         stp_valid = 1'b0;
    logic [W-1:0] stp_rem = '0;
    logic [W-1:0] stp_dvs = '0;
    logic         stp_q = 1'b0;
    logic         stp_m = 1'b0;
    logic         stp_t = 1'b0;
    logic         stp_valid_o;
    logic [W-1:0] stp_rem_o;
    logic         stp_q_o;
    logic         stp_m_o;
    logic         stp_t_o;
    logic         run_start = 1'b0;
    logic [W-1:0] run_hi = '0;
    logic [W-1:0] run_lo = '0;
    logic [W-1:0] run_dvs = '0;
    logic         run_busy;
    logic         run_done;
    logic [W-1:0] run_quot;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    nrdiv_step_unit dut (
        .clk(clk), .rst_n(rst_n),
        .stp_valid(stp_valid), .stp_rem(stp_rem), .stp_dvs(stp_dvs),
        .stp_q(stp_q), .stp_m(stp_m), .stp_t(stp_t),
        .stp_valid_o(stp_valid_o), .stp_rem_o(stp_rem_o),
        .stp_q_o(stp_q_o), .stp_m_o(stp_m_o), .stp_t_o(stp_t_o),
        .run_start(run_start), .run_hi(run_hi), .run_lo(run_lo),
        .run_dvs(run_dvs), .run_busy(run_busy), .run_done(run_done),
        .run_quot(run_quot)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Reference step: returns {rem, q, t}, computed with 64-bit integers
    function automatic logic [W+1:0] ref_step(input logic [W-1:0] rem, input logic [W-1:0] dvs,
                                              input logic q, input logic m, input logic t);
        longint unsigned sh, res;
        logic cb, nq;
        sh = ((longint'(rem) << 1) | longint'(t)) & 64'hFFFF_FFFF;
        if (q == m) begin
            cb  = (sh < longint'(dvs));
            res = (sh - longint'(dvs)) & 64'hFFFF_FFFF;
        end else begin
            res = sh + longint'(dvs);
            cb  = (res > 64'hFFFF_FFFF);
            res = res & 64'hFFFF_FFFF;
        end
        nq = rem[W-1] ^ m ^ cb;
        return {res[W-1:0], nq, (nq == m)};
    endfunction

    // One registered step, checked one clock later (R1, R2, R3, R4, R5)
    task automatic do_step(input logic [W-1:0] rem, input logic [W-1:0] dvs,
                           input logic q, input logic m, input logic t);
        logic [W+1:0] e;
        e = ref_step(rem, dvs, q, m, t);
        stp_valid = 1'b1; stp_rem = rem; stp_dvs = dvs;
        stp_q = q; stp_m = m; stp_t = t;
        @(negedge clk);
        stp_valid = 1'b0;
        check("R5 valid", 64'(stp_valid_o), 64'd1);
        check("R1 remainder", 64'(stp_rem_o), 64'(e[W+1:2]));
        check("R2 q", 64'(stp_q_o), 64'(e[1]));
        check("R3 t", 64'(stp_t_o), 64'(e[0]));
        check("R4 m", 64'(stp_m_o), 64'(m));
    endtask

    // One full run; optionally injects a start while busy (R7, R8, R9, R10)
    task automatic do_run(input logic [W-1:0] hi, input logic [W-1:0] lo,
                          input logic [W-1:0] dvs, input bit inject);
        logic [63:0] expq;
        expq = ({hi, lo} / {32'd0, dvs}) & 64'hFFFF_FFFF;
        run_start = 1'b1; run_hi = hi; run_lo = lo; run_dvs = dvs;
        @(negedge clk);
        run_start = 1'b0;
        check("R7 busy after start", 64'(run_busy), 64'd1);
        for (int i = 1; i < W; i++) begin
            if (inject && i == 10) begin
                run_start = 1'b1; run_hi = '0; run_lo = 32'h1234_5678; run_dvs = 32'd3;
            end
            @(negedge clk);
            run_start = 1'b0;
        end
        check("R7 no early done", 64'(run_done), 64'd0);
        @(negedge clk);
        check("R7 done", 64'(run_done), 64'd1);
        check("R7 busy low at done", 64'(run_busy), 64'd0);
        check(inject ? "R9 quotient" : "R8 quotient", 64'(run_quot), expq);
        @(negedge clk);
        check("R7 done one cycle", 64'(run_done), 64'd0);
        check("R10 quotient held", 64'(run_quot), expq);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        logic [W-1:0] held;
        void'($urandom(32'd2718));
        repeat (3) @(negedge clk);
        // R6: reset state
        check("R6 valid_o", 64'(stp_valid_o), 64'd0);
        check("R6 rem_o", 64'(stp_rem_o), 64'd0);
        check("R6 flags", 64'({stp_q_o, stp_m_o, stp_t_o}), 64'd0);
        check("R6 busy", 64'(run_busy), 64'd0);
        check("R6 done", 64'(run_done), 64'd0);
        check("R6 quot", 64'(run_quot), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // Directed steps, all four flag combinations and wrap corners (R1, R2)
        do_step(32'h8000_0001, 32'h0000_0003, 1'b0, 1'b0, 1'b1);
        do_step(32'h0000_0000, 32'h0000_0001, 1'b0, 1'b0, 1'b0);
        do_step(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0, 1'b1, 1'b1);
        do_step(32'h7FFF_FFFF, 32'h0000_0002, 1'b1, 1'b0, 1'b1);
        do_step(32'hC000_0000, 32'h8000_0000, 1'b1, 1'b1, 1'b0);
        for (int i = 0; i < 40; i++) begin
            do_step($urandom, $urandom, 1'($urandom), 1'($urandom), 1'($urandom));
        end

        // R5: with valid low the outputs hold despite new inputs
        held = stp_rem_o;
        stp_rem = ~stp_rem; stp_dvs = 32'h5555_AAAA; stp_t = ~stp_t;
        @(negedge clk);
        check("R5 valid low", 64'(stp_valid_o), 64'd0);
        check("R5 hold", 64'(stp_rem_o), 64'(held));

        // Directed divisions (R8)
        do_run(32'd0, 32'd100, 32'd7, 1'b0);
        do_run(32'd0, 32'hFFFF_FFFF, 32'd1, 1'b0);
        do_run(32'd0, 32'd5, 32'hFFFF_FFFF, 1'b0);
        do_run(32'hFFFF_FFFE, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0);
        do_run(32'd0, 32'd0, 32'd9, 1'b0);
        // R9: start while busy is ignored
        do_run(32'd0, 32'hDEAD_BEEF, 32'd13, 1'b1);
        // Random divisions (R8)
        for (int i = 0; i < 30; i++) begin
            logic [W-1:0] d, h;
            d = $urandom | 32'd1;
            h = (i % 2 == 0) ? 32'd0 : ($urandom % d);
            do_run(h, $urandom, d, 1'b0);
        end

        // R10: quotient still held after idle clocks
        held = run_quot;
        repeat (5) @(negedge clk);
        check("R10 idle hold", 64'(run_quot), 64'(held));

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule